// File: doc/BRIEF.md
# Shared-Pin Serial Configuration Loader

This block loads a 20-bit control word into a receiver through two pins: a serial clock pin and a data pin that normally carries the receiver's demodulated output. While the loader is idle it owns the data pin whenever the clock pin is low. Raising the clock pin releases the data pin, so an external controller can pull it low and take over the line. A framing pattern of data-pin transitions while the clock is high opens a write. A second pattern closes the write and hands the pin back.

Once a write is open, each clock pulse whose high phase contains no data transition delivers one bit. The bit value is the data level when the clock rises. Bits arrive most significant first and always end at bit 0, so a write of k bits replaces bits k-1..0 and leaves the upper bits alone. The bits collect in a shadow store and reach the live word only when a proper closing pattern ends the write. A malformed high phase discards the whole write. Both pins are sampled by the system clock through synchronisers, so every pin phase must last at least four system clocks.

Top module: `shared_pin_cfg_loader`

## Requirements
- R1: After reset the control word reads 0x00078 (bits 3, 4, 5 and 6 set, all others clear), and the data-pin enable is high while the clock pin is low.
- R2: While idle, the data-pin enable is low whenever the clock pin is high and high whenever it is low, within three system clocks of a pin change.
- R3: A write opens when the clock pin rises with data low, the data pin then rises and falls while the clock is high, and the clock then falls. From then on the data-pin enable stays low.
- R4: During an open write, a clock high phase with no data transition shifts in the data level sampled at the clock rise. A write of k bits (k at most 20) sets bits k-1..0 of the word to those bits, most significant first, and keeps bits 19..k.
- R5: A write closes when the clock pin rises with data high, the data pin falls, rises and falls while the clock stays high, and the clock then falls. The closing pattern applies the collected bits and returns the loader to idle, with the enable high again while the clock is low.
- R6: The control word does not change while a write is open, before the closing pattern.
- R7: During an open write, a clock high phase containing one, two or more than three data transitions (anything other than zero or the closing pattern) discards the write, leaves the word unchanged and returns the loader to idle.
- R8: A write of more than 20 bits leaves the last 20 bits received in the word.
- R9: While idle, a clock high phase whose pattern differs from the opening pattern (data high at the clock rise, for example) opens nothing. Bits and a closing pattern that follow leave the word unchanged.
- R10: An opening pattern followed directly by a closing pattern leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times faster than the shortest pin phase |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkPin | input | 1 | Level on the serial clock pin |
| sdatPin | input | 1 | Level on the shared data pin |
| sdatOe | output | 1 | High when the receiver may drive the data pin |
| cfgWord | output | 20 | Live control word |

## Verification
On every cycle the assertions check four things: the strobes from control to datapath never coincide, the word holds steady except on a commit strobe, the commit mask keeps a contiguous low-aligned shape, and the shifted bit lands at bit 0. They also check that an opening pattern leaves the pin released and that a close or a malformed phase returns the loader to idle. Only the bench scenarios can show the arithmetic result of a partial write at every length from 1 to 20 bits. The same holds for the last-20-bits rule on overlong writes, for the patterns that must be ignored while idle, and for the enable following the clock pin.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;

  // Strobes from the pin-framing control to the register datapath.
  typedef struct packed {
    logic clear;     // a write has opened: empty the shadow store
    logic shiftEn;   // accept one bit into the shadow store
    logic shiftBit;  // value of the accepted bit
    logic commit;    // a valid close: apply the collected bits
  } loadStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOAD = 1'b1
  } linkState_t;

endpackage

// File: rtl/cfgload_ctrl.sv
module cfgload_ctrl
  import cfgload_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int EDGE_CNT_W  = 3,
  parameter int OPEN_EDGES  = 2,
  parameter int CLOSE_EDGES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkPin,
  input  logic        sdatPin,
  output loadStrobe_t strobe,
  output logic        dataOe
);

  localparam logic [EDGE_CNT_W-1:0] CNT_MAX   = {EDGE_CNT_W{1'b1}};
  localparam logic [EDGE_CNT_W-1:0] CNT_OPEN  = EDGE_CNT_W'(OPEN_EDGES);
  localparam logic [EDGE_CNT_W-1:0] CNT_CLOSE = EDGE_CNT_W'(CLOSE_EDGES);

  logic [SYNC_STAGES-1:0] sclkSync;
  logic [SYNC_STAGES-1:0] sdatSync;
  logic                   sclkS, sdatS, sclkP, sdatP;
  logic                   riseClk, fallClk, dataEdge;
  logic [EDGE_CNT_W-1:0]  edgeCnt;
  logic                   lowAtRise;
  logic                   heldBit;
  linkState_t             state;
  logic                   openOk, closeOk, quietPhase;

  // Synchroniser chains for both pins.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkSync <= '0;
          sdatSync <= '0;
        end else begin
          sclkSync <= sclkPin;
          sdatSync <= sdatPin;
        end
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclkSync <= '0;
          sdatSync <= '0;
        end else begin
          sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkPin};
          sdatSync <= {sdatSync[SYNC_STAGES-2:0], sdatPin};
        end
      end
    end
  endgenerate

  assign sclkS = sclkSync[SYNC_STAGES-1];
  assign sdatS = sdatSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkP <= 1'b0;
      sdatP <= 1'b0;
    end else begin
      sclkP <= sclkS;
      sdatP <= sdatS;
    end
  end

  assign riseClk  = sclkS & ~sclkP;
  assign fallClk  = ~sclkS & sclkP;
  assign dataEdge = sdatS ^ sdatP;

  // Per high-phase bookkeeping: level at the rise and transitions seen.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt   <= '0;
      lowAtRise <= 1'b0;
      heldBit   <= 1'b0;
    end else if (riseClk) begin
      edgeCnt   <= '0;
      lowAtRise <= ~sdatS;
      heldBit   <= sdatS;
    end else if (sclkS && dataEdge && edgeCnt != CNT_MAX) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign openOk     = lowAtRise && (edgeCnt == CNT_OPEN);
  assign closeOk    = !lowAtRise && (edgeCnt == CNT_CLOSE);
  assign quietPhase = (edgeCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else if (fallClk) begin
      unique case (state)
        ST_IDLE: if (openOk) state <= ST_LOAD;
        ST_LOAD: if (!quietPhase) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.shiftBit = heldBit;
    if (fallClk) begin
      if (state == ST_IDLE) begin
        strobe.clear = openOk;
      end else begin
        strobe.shiftEn = quietPhase;
        strobe.commit  = closeOk;
      end
    end
  end

  assign dataOe = (state == ST_IDLE) && !sclkS;

  // R5: strobes are never issued together
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clear, strobe.shiftEn, strobe.commit}));

  // R3: an opening pattern releases the pin and enters the load state
  assert_open_enters_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (state == ST_LOAD) && !dataOe);

  // R5: a close returns to idle
  assert_close_to_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (state == ST_IDLE));

  // R7: a noisy high phase during a write aborts it
  assert_abort_to_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && fallClk && !quietPhase && !closeOk) |=> (state == ST_IDLE));

endmodule

// File: rtl/cfgload_dp.sv
module cfgload_dp
  import cfgload_pkg::*;
#(
  parameter int                REG_W     = 20,
  parameter logic [REG_W-1:0]  RESET_VAL = REG_W'(32'h78)
) (
  input  logic             clk,
  input  logic             rstN,
  input  loadStrobe_t      strobe,
  output logic [REG_W-1:0] cfgWord
);

  logic [REG_W-1:0] shadow;
  logic [REG_W-1:0] bitMask;

  // Shadow store: bits enter at bit 0; the mask marks how many arrived.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow  <= '0;
      bitMask <= '0;
    end else if (strobe.clear) begin
      shadow  <= '0;
      bitMask <= '0;
    end else if (strobe.shiftEn) begin
      shadow  <= {shadow[REG_W-2:0], strobe.shiftBit};
      bitMask <= {bitMask[REG_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWord <= RESET_VAL;
    end else if (strobe.commit) begin
      cfgWord <= (cfgWord & ~bitMask) | (shadow & bitMask);
    end
  end

  // R6: the live word moves only on a commit
  assert_hold_without_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> $stable(cfgWord));

  // R4: received bits always form a contiguous run from bit 0
  assert_mask_contiguous_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((bitMask & (bitMask + 1'b1)) == '0));

  // R4: an accepted bit lands at bit 0 of the shadow store
  assert_shift_lsb_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> (shadow[0] == $past(strobe.shiftBit)));

endmodule

// File: rtl/shared_pin_cfg_loader.sv
module shared_pin_cfg_loader
  import cfgload_pkg::*;
#(
  parameter int               REG_W       = 20,
  parameter logic [REG_W-1:0] RESET_VAL   = REG_W'(32'h78),
  parameter int               SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkPin,
  input  logic             sdatPin,
  output logic             sdatOe,
  output logic [REG_W-1:0] cfgWord
);

  loadStrobe_t strobe;

  cfgload_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .EDGE_CNT_W (3),
    .OPEN_EDGES (2),
    .CLOSE_EDGES(3)
  ) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclkPin(sclkPin),
    .sdatPin(sdatPin),
    .strobe (strobe),
    .dataOe (sdatOe)
  );

  cfgload_dp #(
    .REG_W    (REG_W),
    .RESET_VAL(RESET_VAL)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .cfgWord(cfgWord)
  );

endmodule

// File: tb/shared_pin_cfg_loader_tb.sv
module shared_pin_cfg_loader_tb_top;

  localparam int PH = 6;  // system clocks per pin phase

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclkPin = 1'b0;
  logic        sdatPin = 1'b0;
  logic        sdatOe;
  logic [19:0] cfgWord;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [19:0] expWord = 20'h00078;

  always #4 clk = ~clk;

  shared_pin_cfg_loader dut_i (
    .clk    (clk),
    .rstN   (rstN),
    .sclkPin(sclkPin),
    .sdatPin(sdatPin),
    .sdatOe (sdatOe),
    .cfgWord(cfgWord)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitPh();
    repeat (PH) @(negedge clk);
  endtask

  task automatic openSeq();
    sdatPin = 1'b0; waitPh();
    sclkPin = 1'b1; waitPh();
    sdatPin = 1'b1; waitPh();
    sdatPin = 1'b0; waitPh();
    sclkPin = 1'b0; waitPh();
  endtask

  task automatic closeSeq();
    sdatPin = 1'b1; waitPh();
    sclkPin = 1'b1; waitPh();
    sdatPin = 1'b0; waitPh();
    sdatPin = 1'b1; waitPh();
    sdatPin = 1'b0; waitPh();
    sclkPin = 1'b0; waitPh();
  endtask

  task automatic sendBit(input logic b);
    sdatPin = b; waitPh();
    sclkPin = 1'b1; waitPh();
    sclkPin = 1'b0; waitPh();
  endtask

  // Full write with arithmetic model update and checks.
  task automatic writeBits(input logic [31:0] value, input int nbits);
    logic [19:0] m;
    openSeq();
    chk({31'd0, sdatOe}, 32'd0, "R3 pin released after open");
    for (int i = nbits - 1; i >= 0; i--) sendBit(value[i]);
    chk({12'd0, cfgWord}, {12'd0, expWord}, "R6 word held before close");
    closeSeq();
    m = (nbits >= 20) ? 20'hFFFFF : 20'((32'd1 << nbits) - 1);
    expWord = (expWord & ~m) | (value[19:0] & m);
    chk({12'd0, cfgWord}, {12'd0, expWord},
        (nbits > 20) ? "R8 last 20 bits kept" : "R4 partial write result");
    chk({31'd0, sdatOe}, 32'd1, "R5 pin returned after close");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    waitPh();
    // R1
    chk({12'd0, cfgWord}, 32'h00078, "R1 reset word");
    chk({31'd0, sdatOe}, 32'd1, "R1 enable at reset with clock low");

    // R2: idle enable follows the clock pin
    for (int k = 0; k < 3; k++) begin
      sdatPin = k[0];
      sclkPin = 1'b1; waitPh();
      chk({31'd0, sdatOe}, 32'd0, "R2 idle clock high releases pin");
      sclkPin = 1'b0; waitPh();
      chk({31'd0, sdatOe}, 32'd1, "R2 idle clock low drives pin");
    end

    // R4: sweep every write length
    for (int n = 1; n <= 20; n++) begin
      writeBits((n * 32'h2F3A5) ^ 32'hA5A5A, n);
    end
    writeBits(32'hFFFFF, 20);
    writeBits(32'h00000, 20);
    writeBits(32'h00001, 1);

    // R8: overlong write
    writeBits(32'h00ABCDE5, 24);

    // R10: open then close directly
    openSeq();
    closeSeq();
    chk({12'd0, cfgWord}, {12'd0, expWord}, "R10 empty write leaves word");
    chk({31'd0, sdatOe}, 32'd1, "R10 pin returned");

    // R7: one-edge and two-edge high phases abort
    for (int e = 1; e <= 2; e++) begin
      openSeq();
      sendBit(1'b1); sendBit(1'b0); sendBit(1'b1);
      sdatPin = 1'b0; waitPh();
      sclkPin = 1'b1; waitPh();
      sdatPin = 1'b1; waitPh();
      if (e == 2) begin sdatPin = 1'b0; waitPh(); end
      sclkPin = 1'b0; waitPh();
      chk({31'd0, sdatOe}, 32'd1, "R7 abort returns pin");
      closeSeq();
      chk({12'd0, cfgWord}, {12'd0, expWord}, "R7 abort leaves word");
    end

    // R9: idle pattern starting high opens nothing
    sdatPin = 1'b1; waitPh();
    sclkPin = 1'b1; waitPh();
    sdatPin = 1'b0; waitPh();
    sdatPin = 1'b1; waitPh();
    sclkPin = 1'b0; waitPh();
    chk({31'd0, sdatOe}, 32'd1, "R9 still driving after fake open");
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b0); sendBit(1'b0);
    closeSeq();
    chk({12'd0, cfgWord}, {12'd0, expWord}, "R9 word unchanged");

    // R9: a single-edge idle phase with data low at rise
    sdatPin = 1'b0; waitPh();
    sclkPin = 1'b1; waitPh();
    sdatPin = 1'b1; waitPh();
    sclkPin = 1'b0; waitPh();
    chk({31'd0, sdatOe}, 32'd1, "R9 single edge opens nothing");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule